// File: doc/BRIEF.md
# Link Test Pattern Generator and Checker

This block drives and checks test patterns on a 10-bit parallel word path, one word per transfer. The transmit side produces words for a serializer. It can produce a pseudo-random sequence of period 127 bits or one of three fixed patterns: a high-frequency toggle, a low-frequency square wave, and a mixed pattern that alternates the two disparity forms of the K28.5 comma character. The receive side checks words coming back from a deserializer. It synchronizes to the stream on its own, counts errored words in a saturating counter and reports whether it has locked.

Each side has its own enable. Both sides share one 3-bit pattern select. The pseudo-random source is started by a side's own control bit or by a shared pin input, and it takes priority over the pattern select. Select codes 3 and 4 are accepted as the long and short compliance frame streams, but they are not generated. These codes and the reserved codes 5 to 7 make the generator send a fixed idle word and leave the checker inactive.

Flow control: the transmit output is valid/ready. A word is transferred on a rising clock edge where tx_valid and tx_ready are both high. While tx_valid is high and tx_ready is low, tx_data holds its value. The receive input is valid/ready with rx_ready tied high, so the checker never applies back-pressure and takes a word on every edge where rx_valid is high.

Top module: `lnk_tpat_engine`

## Requirements
- R1: After reset, tx_valid is 0, chk_lock is 0, err_count is 0 and rx_ready is 1. The sequence register starts at all ones and the mixed pattern starts with 10'h0FA.
- R2: The generator is in pseudo-random mode when prbs_gen_bit or prbs_pin is high, whatever pat_gen_en and pat_sel are. Otherwise it follows pat_sel while pat_gen_en is high. tx_valid is high exactly when one of these is active.
- R3: The pseudo-random sequence uses x^7+x^6+1. Each step shifts s[6]^s[5] into bit 0 of the 7-bit state. The ten new bits of a word are placed from tx_data[0] to tx_data[9]. The state moves on only when a word is transferred.
- R4: pat_sel 0 sends 10'h2AA and pat_sel 1 sends 10'h3E0. pat_sel 2 alternates between 10'h0FA and 10'h305, moving to the other form on each transferred word.
- R5: pat_sel values 3 through 7 make the generator send the idle word 10'h17C.
- R6: tx_data stays stable while tx_valid is high and tx_ready is low, as long as the generator mode does not change.
- R7: The checker is in pseudo-random mode when prbs_chk_bit or prbs_pin is high. Otherwise, while pat_chk_en is high and pat_sel is 0, 1 or 2, it checks that pattern. In any other case it is inactive: chk_lock is 0 and err_count does not change.
- R8: In pseudo-random mode the first word after the checker becomes active only seeds the checker. Each later word is compared with the word that the sequence produces from a state rebuilt from the previous received word, where s[k] = previous[9-k].
- R9: In pattern 0 or 1 a word is errored when it differs from its fixed word. In pattern 2 a word is errored when it is neither 10'h0FA nor 10'h305, or when it equals the previous received word.
- R10: chk_lock rises after 8 consecutive judged words with no error. An errored word while unlocked restarts that count.
- R11: While locked, judged words are grouped into windows of 16 that start at lock. The 4th errored word inside one window clears chk_lock.
- R12: err_count rises by one for each errored judged word, locked or not, and saturates at 16'hFFFF.
- R13: err_clr clears err_count on the next edge, and the clear wins over an increment in the same cycle.
- R14: In the cycle where the checker mode changes, any word presented is discarded, and the sync and lock state restart. err_count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prbs_pin | input | 1 | Shared pseudo-random enable pin for both sides |
| prbs_gen_bit | input | 1 | Pseudo-random generator control bit |
| prbs_chk_bit | input | 1 | Pseudo-random checker control bit |
| pat_gen_en | input | 1 | Pattern generator enable |
| pat_chk_en | input | 1 | Pattern checker enable |
| pat_sel | input | 3 | Pattern select shared by both sides |
| tx_data | output | 10 | Generated word |
| tx_valid | output | 1 | Generated word is valid |
| tx_ready | input | 1 | Downstream accepts the word |
| rx_data | input | 10 | Received word |
| rx_valid | input | 1 | Received word is valid |
| rx_ready | output | 1 | Checker accepts a word (always 1) |
| err_clr | input | 1 | Clear strobe for the error counter |
| chk_lock | output | 1 | Checker locked |
| err_count | output | 16 | Saturating count of errored words |

## Verification
A wrong sequence state or mixed-pattern phase shows at tx_data as soon as the next word is transferred. A stalled transfer that changes its word shows one cycle into the stall. On the receive side, a bad sync word or comparison shows in err_count one edge after the word it misjudged. A wrong run counter or window counter shows as chk_lock changing one edge away from the word that should have set or cleared it. The bench therefore checks lock and count after every received word, both in random streams with injected errors and at the exact window and saturation boundaries.

// File: rtl/lnk_tpat_pkg.sv
package lnk_tpat_pkg;

  localparam int WORD_W = 10;
  localparam int SEQ_W  = 7;

  localparam logic [WORD_W-1:0] HF_WORD   = 10'h2AA;
  localparam logic [WORD_W-1:0] LF_WORD   = 10'h3E0;
  localparam logic [WORD_W-1:0] KNEG_WORD = 10'h0FA;
  localparam logic [WORD_W-1:0] KPOS_WORD = 10'h305;
  localparam logic [WORD_W-1:0] IDLE_WORD = 10'h17C;

  typedef enum logic [2:0] {
    GEN_OFF, GEN_PRBS, GEN_HF, GEN_LF, GEN_MIX, GEN_IDLE
  } gen_mode_e;

  typedef enum logic [2:0] {
    CHK_OFF, CHK_PRBS, CHK_HF, CHK_LF, CHK_MIX
  } chk_mode_e;

  // Word produced by WORD_W steps of x^7+x^6+1, first bit into position 0.
  function automatic logic [WORD_W-1:0] seq_word(input logic [SEQ_W-1:0] st);
    logic [SEQ_W-1:0]  s;
    logic [WORD_W-1:0] w;
    s = st;
    w = '0;
    for (int i = 0; i < WORD_W; i++) begin
      w[i] = s[6] ^ s[5];
      s    = {s[SEQ_W-2:0], w[i]};
    end
    return w;
  endfunction

  function automatic logic [SEQ_W-1:0] seq_advance(input logic [SEQ_W-1:0] st);
    logic [SEQ_W-1:0] s;
    s = st;
    for (int i = 0; i < WORD_W; i++) s = {s[SEQ_W-2:0], s[6] ^ s[5]};
    return s;
  endfunction

  // State that follows a received word: newest bit sits in position 0.
  function automatic logic [SEQ_W-1:0] seq_recover(input logic [WORD_W-1:0] w);
    logic [SEQ_W-1:0] s;
    for (int k = 0; k < SEQ_W; k++) s[k] = w[WORD_W-1-k];
    return s;
  endfunction

endpackage

// File: rtl/lnk_tpat_gen.sv
module lnk_tpat_gen
  import lnk_tpat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  gen_mode_e         mode,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid
);

  logic [SEQ_W-1:0] seq_q;
  logic             phase_q;
  logic             xfer;

  assign tx_valid = (mode != GEN_OFF);
  assign xfer     = tx_valid && tx_ready;

  always_comb begin
    unique case (mode)
      GEN_PRBS: tx_data = seq_word(seq_q);
      GEN_HF:   tx_data = HF_WORD;
      GEN_LF:   tx_data = LF_WORD;
      GEN_MIX:  tx_data = phase_q ? KPOS_WORD : KNEG_WORD;
      GEN_IDLE: tx_data = IDLE_WORD;
      default:  tx_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= '1;
      phase_q <= 1'b0;
    end else if (xfer) begin
      if (mode == GEN_PRBS) seq_q   <= seq_advance(seq_q);
      if (mode == GEN_MIX)  phase_q <= ~phase_q;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> ($stable(tx_data) || !$stable(mode))); // R6

  AST_MIX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == GEN_MIX && xfer) |=> (mode != GEN_MIX || tx_data == ~$past(tx_data))); // R4

endmodule

// File: rtl/lnk_tpat_chk.sv
module lnk_tpat_chk
  import lnk_tpat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chk_mode_e         mode,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              restart,
  output logic              judged,
  output logic              bad
);

  chk_mode_e         mode_q;
  logic [WORD_W-1:0] prev_q;
  logic              have_q;

  assign restart = (mode != mode_q) || (mode == CHK_OFF);

  always_comb begin
    judged = 1'b0;
    bad    = 1'b0;
    if (rx_valid && !restart) begin
      unique case (mode)
        CHK_PRBS: begin
          judged = have_q;
          bad    = have_q && (rx_data != seq_word(seq_recover(prev_q)));
        end
        CHK_HF: begin
          judged = 1'b1;
          bad    = (rx_data != HF_WORD);
        end
        CHK_LF: begin
          judged = 1'b1;
          bad    = (rx_data != LF_WORD);
        end
        CHK_MIX: begin
          judged = 1'b1;
          bad    = !(rx_data == KNEG_WORD || rx_data == KPOS_WORD)
                   || (have_q && rx_data == prev_q);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CHK_OFF;
      prev_q <= '0;
      have_q <= 1'b0;
    end else begin
      mode_q <= mode;
      if (restart) begin
        have_q <= 1'b0;
      end else if (rx_valid) begin
        prev_q <= rx_data;
        have_q <= 1'b1;
      end
    end
  end

  AST_SEED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && mode == CHK_PRBS) |=> (mode != CHK_PRBS || !judged)); // R8

endmodule

// File: rtl/lnk_tpat_mon.sv
module lnk_tpat_mon #(
  parameter int CNT_W     = 16,
  parameter int LOCK_RUN  = 8,
  parameter int LOSS_ERRS = 4,
  parameter int WIN_LEN   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             judged,
  input  logic             bad,
  input  logic             err_clr,
  output logic             lock,
  output logic [CNT_W-1:0] err_count
);

  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int WERR_W = $clog2(LOSS_ERRS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [RUN_W-1:0]  run_q;
  logic [WIN_W-1:0]  win_q;
  logic [WERR_W-1:0] werr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock   <= 1'b0;
      run_q  <= '0;
      win_q  <= '0;
      werr_q <= '0;
    end else if (restart) begin
      lock   <= 1'b0;
      run_q  <= '0;
      win_q  <= '0;
      werr_q <= '0;
    end else if (judged) begin
      if (!lock) begin
        if (bad) begin
          run_q <= '0;
        end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
          lock   <= 1'b1;
          run_q  <= '0;
          win_q  <= '0;
          werr_q <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else if (bad && werr_q == WERR_W'(LOSS_ERRS - 1)) begin
        lock  <= 1'b0;
        run_q <= '0;
      end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
        win_q  <= '0;
        werr_q <= '0;
      end else begin
        win_q  <= win_q + 1'b1;
        werr_q <= werr_q + WERR_W'(bad);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   err_count <= '0;
    else if (err_clr)                             err_count <= '0;
    else if (judged && bad && err_count != CNT_MAX) err_count <= err_count + 1'b1;
  end

  AST_LOCK_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(judged && !bad)); // R10

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !err_clr) |=> err_count == CNT_MAX); // R12

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + CNT_W'(1))); // R12

  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> err_count == '0); // R13

endmodule

// File: rtl/lnk_tpat_engine.sv
module lnk_tpat_engine
  import lnk_tpat_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int LOCK_RUN  = 8,
  parameter int LOSS_ERRS = 4,
  parameter int WIN_LEN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prbs_pin,
  input  logic              prbs_gen_bit,
  input  logic              prbs_chk_bit,
  input  logic              pat_gen_en,
  input  logic              pat_chk_en,
  input  logic [2:0]        pat_sel,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              err_clr,
  output logic              chk_lock,
  output logic [CNT_W-1:0]  err_count
);

  gen_mode_e gen_mode;
  chk_mode_e chk_mode;
  logic      restart, judged, bad;

  assign rx_ready = 1'b1;

  always_comb begin
    gen_mode = GEN_OFF;
    if (prbs_gen_bit || prbs_pin) gen_mode = GEN_PRBS;
    else if (pat_gen_en) begin
      unique case (pat_sel)
        3'd0:    gen_mode = GEN_HF;
        3'd1:    gen_mode = GEN_LF;
        3'd2:    gen_mode = GEN_MIX;
        default: gen_mode = GEN_IDLE;
      endcase
    end
  end

  always_comb begin
    chk_mode = CHK_OFF;
    if (prbs_chk_bit || prbs_pin) chk_mode = CHK_PRBS;
    else if (pat_chk_en) begin
      unique case (pat_sel)
        3'd0:    chk_mode = CHK_HF;
        3'd1:    chk_mode = CHK_LF;
        3'd2:    chk_mode = CHK_MIX;
        default: chk_mode = CHK_OFF;
      endcase
    end
  end

  lnk_tpat_gen u_gen (
    .clk(clk), .rst_n(rst_n), .mode(gen_mode),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_valid(tx_valid)
  );

  lnk_tpat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(chk_mode),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .restart(restart), .judged(judged), .bad(bad)
  );

  lnk_tpat_mon #(
    .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN), .LOSS_ERRS(LOSS_ERRS), .WIN_LEN(WIN_LEN)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .restart(restart), .judged(judged), .bad(bad),
    .err_clr(err_clr), .lock(chk_lock), .err_count(err_count)
  );

  AST_OFF_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_mode == CHK_OFF) |=> !chk_lock); // R7

  AST_IDLE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (!prbs_gen_bit && !prbs_pin && pat_gen_en && pat_sel > 3'd2) |-> (tx_valid && tx_data == IDLE_WORD)); // R5

endmodule

// File: tb/lnk_tpat_engine_tb.sv
`timescale 1ns/1ps
module lnk_tpat_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prbs_pin = 0, prbs_gen_bit = 0, prbs_chk_bit = 0;
  logic        pat_gen_en = 0, pat_chk_en = 0;
  logic [2:0]  pat_sel = 3'd0;
  logic [9:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 0;
  logic [9:0]  rx_data = '0;
  logic        rx_valid = 0;
  logic        rx_ready;
  logic        err_clr = 0;
  logic        chk_lock;
  logic [15:0] err_count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lnk_tpat_engine u_dut (
    .clk(clk), .rst_n(rst_n), .prbs_pin(prbs_pin), .prbs_gen_bit(prbs_gen_bit),
    .prbs_chk_bit(prbs_chk_bit), .pat_gen_en(pat_gen_en), .pat_chk_en(pat_chk_en),
    .pat_sel(pat_sel), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .err_clr(err_clr),
    .chk_lock(chk_lock), .err_count(err_count)
  );

  // ---- bench reference of the sequence (from R3 / R8) ----
  function automatic logic [9:0] b_word(input logic [6:0] st);
    logic [6:0] s = st;
    logic [9:0] w;
    for (int i = 0; i < 10; i++) begin
      w[i] = s[6] ^ s[5];
      s = {s[5:0], w[i]};
    end
    return w;
  endfunction

  function automatic logic [6:0] b_next(input logic [6:0] st);
    logic [6:0] s = st;
    for (int i = 0; i < 10; i++) s = {s[5:0], s[6] ^ s[5]};
    return s;
  endfunction

  function automatic logic [6:0] b_state(input logic [9:0] w);
    logic [6:0] s;
    for (int k = 0; k < 7; k++) s[k] = w[9-k];
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- checker model (R7..R14); modes: 0 off,1 prbs,2 hf,3 lf,4 mix ----
  int         m_mode = 0;
  logic [9:0] m_prev;
  bit         m_have, m_lock;
  int         m_run, m_win, m_werr;
  int         m_cnt = 0;

  function automatic int mode_of();
    if (prbs_chk_bit || prbs_pin) return 1;
    if (pat_chk_en && pat_sel <= 3'd2) return 2 + int'(pat_sel);
    return 0;
  endfunction

  task automatic m_restart();
    m_have = 0; m_lock = 0; m_run = 0; m_win = 0; m_werr = 0;
  endtask

  task automatic m_take(input logic [9:0] w);
    bit j, b;
    j = 0; b = 0;
    case (m_mode)
      1: begin j = m_have; b = m_have && (w != b_word(b_state(m_prev))); end
      2: begin j = 1; b = (w != 10'h2AA); end
      3: begin j = 1; b = (w != 10'h3E0); end
      4: begin j = 1; b = !(w == 10'h0FA || w == 10'h305) || (m_have && w == m_prev); end
      default: ;
    endcase
    if (m_mode != 0) begin m_prev = w; m_have = 1; end
    if (j) begin
      if (b && m_cnt < 65535) m_cnt++;
      if (!m_lock) begin
        if (b) m_run = 0;
        else if (m_run == 7) begin m_lock = 1; m_run = 0; m_win = 0; m_werr = 0; end
        else m_run++;
      end else if (b && m_werr == 3) begin
        m_lock = 0; m_run = 0;
      end else if (m_win == 15) begin
        m_win = 0; m_werr = 0;
      end else begin
        m_win++; m_werr += int'(b);
      end
    end
  endtask

  task automatic set_chk(input bit pbit, input bit pin, input bit en, input logic [2:0] sel);
    int nm;
    @(negedge clk);
    prbs_chk_bit = pbit; prbs_pin = pin; pat_chk_en = en; pat_sel = sel; rx_valid = 0;
    nm = mode_of();
    if (nm != m_mode || nm == 0) m_restart();
    m_mode = nm;
    @(posedge clk); #1;
    check("R14 lock after mode set", chk_lock, m_lock);
  endtask

  task automatic rx_word(input logic [9:0] w, input string req);
    @(negedge clk);
    rx_valid = 1; rx_data = w;
    @(posedge clk); #1;
    rx_valid = 0;
    m_take(w);
    check({req, " lock"}, chk_lock, m_lock);
    check({req, " count"}, err_count, m_cnt);
  endtask

  // ---- watchdog ----
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] gs;
    logic [9:0] w;
    bit         ph;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    check("R1 tx_valid", tx_valid, 0);
    check("R1 lock", chk_lock, 0);
    check("R1 count", err_count, 0);
    check("R1 rx_ready", rx_ready, 1);
    @(negedge clk); rst_n = 1;

    // ---- generator: fixed patterns, idle codes, back-pressure ----
    @(negedge clk); pat_gen_en = 1; pat_sel = 3'd0; tx_ready = 1; #1;
    check("R2 tx_valid pattern", tx_valid, 1);
    check("R4 hf word", tx_data, 10'h2AA);
    @(negedge clk); pat_sel = 3'd1; #1;
    check("R4 lf word", tx_data, 10'h3E0);
    @(negedge clk); pat_sel = 3'd2; tx_ready = 0; #1;
    check("R1 mixed first form", tx_data, 10'h0FA);
    repeat (3) @(negedge clk);
    check("R6 hold while stalled", tx_data, 10'h0FA);
    ph = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); tx_ready = $urandom % 2; #1;
      check("R4 mixed alternation", tx_data, ph ? 10'h305 : 10'h0FA);
      @(posedge clk); if (tx_ready) ph = ~ph;
    end
    for (int c = 3; c < 8; c++) begin
      @(negedge clk); pat_sel = 3'(c); #1;
      check("R5 idle word", tx_data, 10'h17C);
    end
    @(negedge clk); pat_gen_en = 0; tx_ready = 1; #1;
    check("R2 off", tx_valid, 0);

    // ---- generator: pseudo-random via bit, then pin, with random ready ----
    gs = 7'h7F;
    @(negedge clk); prbs_gen_bit = 1; pat_gen_en = 1; pat_sel = 3'd1; tx_ready = 0; #1;
    check("R2 prbs priority", tx_data, b_word(gs));
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (i == 60) begin prbs_gen_bit = 0; prbs_pin = 1; end
      tx_ready = ($urandom % 4) != 0; #1;
      check("R3 sequence word", tx_data, b_word(gs));
      check("R2 valid", tx_valid, 1);
      @(posedge clk); if (tx_ready) gs = b_next(gs);
    end
    @(negedge clk); prbs_pin = 0; pat_gen_en = 0; tx_ready = 0;

    // ---- checker: lock and loss windows in HF ----
    set_chk(0, 0, 1, 3'd0);
    for (int i = 0; i < 7; i++) rx_word(10'h2AA, "R10 run");
    check("R10 not yet locked", chk_lock, 0);
    rx_word(10'h2AA, "R10 run");
    check("R10 locked at 8", chk_lock, 1);
    for (int i = 0; i < 3; i++) rx_word(10'h000, "R11 errs");
    for (int i = 0; i < 13; i++) rx_word(10'h2AA, "R11 fill");
    for (int i = 0; i < 3; i++) rx_word(10'h001, "R11 errs");
    check("R11 three in new window", chk_lock, 1);
    rx_word(10'h002, "R11 fourth");
    check("R11 lock lost", chk_lock, 0);

    // ---- mode change discards the word of that cycle ----
    @(negedge clk); pat_sel = 3'd1; rx_valid = 1; rx_data = 10'h000;
    m_restart(); m_mode = 3;
    @(posedge clk); #1; rx_valid = 0;
    check("R14 word discarded", err_count, m_cnt);
    check("R14 lock cleared", chk_lock, 0);

    // ---- inactive codes: no count, no lock ----
    set_chk(0, 0, 1, 3'd3);
    for (int i = 0; i < 10; i++) rx_word(10'h0FF, "R7 inactive");
    set_chk(0, 0, 1, 3'd6);
    for (int i = 0; i < 10; i++) rx_word(10'h2AA, "R7 reserved");

    // ---- random segments ----
    for (int seg = 0; seg < 16; seg++) begin
      int pick;
      pick = $urandom % 7;
      case (pick)
        0: set_chk(1, 0, 0, 3'd0);
        1: set_chk(0, 1, 1, 3'd2);
        2: set_chk(0, 0, 1, 3'd0);
        3: set_chk(0, 0, 1, 3'd1);
        4: set_chk(0, 0, 1, 3'd2);
        5: set_chk(0, 0, 1, 3'(3 + $urandom % 5));
        default: set_chk(0, 0, 0, 3'd0);
      endcase
      gs = 7'($urandom % 127 + 1);
      ph = $urandom % 2;
      for (int i = 0; i < 70; i++) begin
        case (m_mode)
          1: begin w = b_word(gs); gs = b_next(gs); end
          2: w = 10'h2AA;
          3: w = 10'h3E0;
          4: begin w = ph ? 10'h305 : 10'h0FA; ph = ~ph; end
          default: w = 10'($urandom);
        endcase
        if ($urandom % 12 == 0) w = w ^ 10'($urandom % 1023 + 1);
        if ($urandom % 8 == 0) begin @(negedge clk); rx_valid = 0; end
        rx_word(w, "R8 R9 R12 random");
      end
    end

    // ---- saturation and clear ----
    set_chk(0, 0, 1, 3'd0);
    for (int i = 0; i < 65600; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 10'h155;
      @(posedge clk); #1; m_take(10'h155);
    end
    rx_valid = 0;
    check("R12 saturated", err_count, 16'hFFFF);
    @(negedge clk); err_clr = 1; rx_valid = 1; rx_data = 10'h000;
    @(posedge clk); #1; err_clr = 0; rx_valid = 0;
    m_take(10'h000); m_cnt = 0;
    check("R13 clear wins", err_count, 0);
    rx_word(10'h3FF, "R13 count after clear");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule